// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front End

This block is the software-visible side of a small SPI controller. It decodes word-aligned reads and writes from a simple single-cycle bus. It holds the configuration, controller-enable, delay, slave-idle-count and TX watermark registers, and it presents their values to the serial engine on dedicated outputs. Writes to the TX data address become one-cycle push strobes toward an external TX FIFO. Reads of the RX data address return the head byte of an external RX FIFO and raise a one-cycle pop strobe.

The block also collects interrupt sources. Two events are latched: a mode fault reported by the engine, and the TX FIFO level dropping below the watermark. Two levels are passed straight through: TX FIFO full and RX FIFO not empty. A mask is changed through separate set and clear addresses, and a registered interrupt line is the OR of the status bits that the mask lets through. The watermark register keeps only as many bits as the FIFO depth needs, so software can find the depth by writing all ones and reading the value back.

Top module: `spi_csr_unit`

## Requirements
- R1: Synchronous active-high reset clears config, enable, delay, idle count, mask, latched status bits, strobes, read data and the interrupt output, and sets the watermark to 1.
- R2: Config (byte offset 0x00, low CFG_W bits kept), controller enable (0x14, bit 0 only), delay (0x18) and idle count (0x24, low IDLE_W bits kept) read back what was written and drive cfg_word, ctrl_en, delay_word and idle_count.
- R3: The watermark (0x28) keeps log2(FIFO_DEPTH) bits. Writing 0xFFFF reads back FIFO_DEPTH-1, which is 15 by default. The value drives wm_level.
- R4: Writing ones to 0x08 sets those mask bits and writing ones to 0x0C clears them. Both use bits 6:0. The mask reads back at 0x10.
- R5: Status (0x04) bit layout: bit 1 mode fault, bit 2 TX below watermark, bit 3 TX FIFO full, bit 4 RX FIFO not empty, other bits 0. Writing a one to a latched bit clears it. Zero bits in the write leave it unchanged.
- R6: A mode_fault pulse sets status bit 1. A set in the same cycle as a clearing write wins.
- R7: Status bit 2 is set on the cycle after tx_level < watermark becomes true (rising edge). Once cleared, it is not set again while the condition stays true.
- R8: Status bits 3 and 4 show tx_full and rx_nonempty of the previous clock. Writing ones to them has no effect.
- R9: irq equals, one cycle later, the OR of (status AND mask).
- R10: A write to 0x1C gives one tx_push cycle right after the write, with tx_byte equal to the written bits 7:0.
- R11: A read of 0x20 returns rx_byte as it was during the access and gives one rx_pop cycle right after it.
- R12: Read data appears on bus_rdata in the cycle after the access and is 0 in every other cycle. Reads of 0x08, 0x0C, 0x1C and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| tx_push | output | 1 | Push strobe to TX FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop strobe to RX FIFO |
| rx_byte | input | 8 | RX FIFO head byte |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_full | input | 1 | TX FIFO full |
| rx_nonempty | input | 1 | RX FIFO holds data |
| mode_fault | input | 1 | Mode fault event pulse |
| cfg_word | output | CFG_W | Configuration register |
| ctrl_en | output | 1 | Controller enable |
| delay_word | output | DLY_W | Delay register |
| idle_count | output | IDLE_W | Slave idle count |
| wm_level | output | WM_W | TX watermark |
| irq | output | 1 | Level interrupt |

## Verification
A latched status bit or mask bit in a wrong state appears at irq one cycle later, but only when the matching mask bit is set. For that reason the bench compares irq every clock while mask patterns and sources change. A missed or extra edge on the watermark detector shows as a status bit 2 that is set after a clear while the level stays low, or as a rise that is never seen. The bench sees this on the next status read. Strobe and read-data timing errors show in the very next cycle, because the reference model predicts tx_push, rx_pop and bus_rdata for every clock.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  localparam int NREG  = 11;
  localparam int IRQ_W = 7;

  typedef enum logic [3:0] {
    RI_CFG  = 4'd0,
    RI_STAT = 4'd1,
    RI_MSET = 4'd2,
    RI_MCLR = 4'd3,
    RI_MASK = 4'd4,
    RI_EN   = 4'd5,
    RI_DLY  = 4'd6,
    RI_TXD  = 4'd7,
    RI_RXD  = 4'd8,
    RI_IDLE = 4'd9,
    RI_WM   = 4'd10
  } reg_idx_e;

  localparam int IB_MODF   = 1;
  localparam int IB_TXLOW  = 2;
  localparam int IB_TXFULL = 3;
  localparam int IB_RXNE   = 4;
endpackage

// File: rtl/spi_csr_decode.sv
module spi_csr_decode #(
  parameter int ADDR_W = 6,
  parameter int NREG   = 11
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lsb;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = bus_addr[1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = bus_sel &  bus_wr & (idx == IDX_W'(i));
    assign rd_hit[i] = bus_sel & ~bus_wr & (idx == IDX_W'(i));
  end
endmodule

// File: rtl/spi_csr_cfg.sv
module spi_csr_cfg
  import spi_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 18,
  parameter int DLY_W  = 32,
  parameter int IDLE_W = 8,
  parameter int WM_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              en_q,
  output logic [DLY_W-1:0]  dly_q,
  output logic [IDLE_W-1:0] idle_q,
  output logic [WM_W-1:0]   wm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      dly_q  <= '0;
      idle_q <= '0;
      wm_q   <= WM_W'(1);
    end else begin
      if (wr_hit[RI_CFG])  cfg_q  <= wdata[CFG_W-1:0];
      if (wr_hit[RI_EN])   en_q   <= wdata[0];
      if (wr_hit[RI_DLY])  dly_q  <= wdata[DLY_W-1:0];
      if (wr_hit[RI_IDLE]) idle_q <= wdata[IDLE_W-1:0];
      if (wr_hit[RI_WM])   wm_q   <= wdata[WM_W-1:0];
    end
  end
endmodule

// File: rtl/spi_csr_irq.sv
module spi_csr_irq
  import spi_csr_pkg::*;
#(
  parameter int WM_W  = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mset,
  input  logic             wr_mclr,
  input  logic             wr_stat,
  input  logic [IRQ_W-1:0] wbits,
  input  logic             mode_fault,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [WM_W-1:0]  wm,
  input  logic             tx_full,
  input  logic             rx_nonempty,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] stat_lat,
  output logic [IRQ_W-1:0] stat_view,
  output logic             irq_q
);
  logic modf_q, txlow_q, below_prev, below_now;
  logic full_q, rxne_q;

  assign below_now = tx_level < LVL_W'(wm);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      modf_q     <= 1'b0;
      txlow_q    <= 1'b0;
      below_prev <= 1'b0;
      full_q     <= 1'b0;
      rxne_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_mset)      mask_q <= mask_q | wbits;
      else if (wr_mclr) mask_q <= mask_q & ~wbits;
      modf_q     <= (modf_q  & ~(wr_stat & wbits[IB_MODF]))  | mode_fault;
      txlow_q    <= (txlow_q & ~(wr_stat & wbits[IB_TXLOW])) | (below_now & ~below_prev);
      below_prev <= below_now;
      full_q     <= tx_full;
      rxne_q     <= rx_nonempty;
      irq_q      <= |(stat_view & mask_q);
    end
  end

  always_comb begin
    stat_lat            = '0;
    stat_lat[IB_MODF]   = modf_q;
    stat_lat[IB_TXLOW]  = txlow_q;
    stat_view           = stat_lat;
    stat_view[IB_TXFULL] = full_q;
    stat_view[IB_RXNE]   = rxne_q;
  end
endmodule

// File: rtl/spi_csr_unit.sv
module spi_csr_unit
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 18,
  parameter int DLY_W      = 32,
  parameter int IDLE_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int WM_W      = $clog2(FIFO_DEPTH),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_full,
  input  logic              rx_nonempty,
  input  logic              mode_fault,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              ctrl_en,
  output logic [DLY_W-1:0]  delay_word,
  output logic [IDLE_W-1:0] idle_count,
  output logic [WM_W-1:0]   wm_level,
  output logic              irq
);
  logic [NREG-1:0]   wr_hit, rd_hit;
  logic [IRQ_W-1:0]  mask_q, stat_lat, stat_view;
  logic [DATA_W-1:0] rd_mux;

  spi_csr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  spi_csr_cfg #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .DLY_W(DLY_W), .IDLE_W(IDLE_W), .WM_W(WM_W)
  ) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_hit(wr_hit),
    .wdata (bus_wdata),
    .cfg_q (cfg_word),
    .en_q  (ctrl_en),
    .dly_q (delay_word),
    .idle_q(idle_count),
    .wm_q  (wm_level)
  );

  spi_csr_irq #(.WM_W(WM_W), .LVL_W(LVL_W)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .wr_mset    (wr_hit[RI_MSET]),
    .wr_mclr    (wr_hit[RI_MCLR]),
    .wr_stat    (wr_hit[RI_STAT]),
    .wbits      (bus_wdata[IRQ_W-1:0]),
    .mode_fault (mode_fault),
    .tx_level   (tx_level),
    .wm         (wm_level),
    .tx_full    (tx_full),
    .rx_nonempty(rx_nonempty),
    .mask_q     (mask_q),
    .stat_lat   (stat_lat),
    .stat_view  (stat_view),
    .irq_q      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_hit[RI_CFG])  rd_mux = DATA_W'(cfg_word);
    if (rd_hit[RI_STAT]) rd_mux = DATA_W'(stat_view);
    if (rd_hit[RI_MASK]) rd_mux = DATA_W'(mask_q);
    if (rd_hit[RI_EN])   rd_mux = DATA_W'(ctrl_en);
    if (rd_hit[RI_DLY])  rd_mux = DATA_W'(delay_word);
    if (rd_hit[RI_RXD])  rd_mux = DATA_W'(rx_byte);
    if (rd_hit[RI_IDLE]) rd_mux = DATA_W'(idle_count);
    if (rd_hit[RI_WM])   rd_mux = DATA_W'(wm_level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_push   <= 1'b0;
      tx_byte   <= '0;
      rx_pop    <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      tx_push   <= wr_hit[RI_TXD];
      rx_pop    <= rd_hit[RI_RXD];
      if (wr_hit[RI_TXD]) tx_byte <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/spi_csr_unit_chk.sv
module spi_csr_unit_chk
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int WM_W   = 4,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tx_push,
  input logic [7:0]        tx_byte,
  input logic              rx_pop,
  input logic [LVL_W-1:0]  tx_level,
  input logic [WM_W-1:0]   wm_level,
  input logic              mode_fault,
  input logic [IRQ_W-1:0]  mask_q,
  input logic [IRQ_W-1:0]  stat_lat,
  input logic [IRQ_W-1:0]  stat_view,
  input logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic hit_txd, hit_rxd, hit_mclr;
  assign hit_txd  = bus_sel &  bus_wr & (bus_addr[ADDR_W-1:2] == IDX_W'(RI_TXD));
  assign hit_rxd  = bus_sel & ~bus_wr & (bus_addr[ADDR_W-1:2] == IDX_W'(RI_RXD));
  assign hit_mclr = bus_sel &  bus_wr & (bus_addr[ADDR_W-1:2] == IDX_W'(RI_MCLR));

  // R6
  modf_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> stat_lat[IB_MODF]);

  // R7
  txlow_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_lat[IB_TXLOW]) |-> $past(tx_level < LVL_W'(wm_level)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(stat_view & mask_q))));

  // R10
  push_chk: assert property (@(posedge clk) disable iff (rst)
    hit_txd |=> (tx_push && tx_byte == $past(bus_wdata[7:0])));

  // R11
  pop_chk: assert property (@(posedge clk) disable iff (rst)
    hit_rxd |=> rx_pop);

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    hit_mclr |=> ((mask_q & $past(bus_wdata[IRQ_W-1:0])) == '0));
endmodule

bind spi_csr_unit spi_csr_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WM_W(WM_W), .LVL_W(LVL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tx_push   (tx_push),
  .tx_byte   (tx_byte),
  .rx_pop    (rx_pop),
  .tx_level  (tx_level),
  .wm_level  (wm_level),
  .mode_fault(mode_fault),
  .mask_q    (mask_q),
  .stat_lat  (stat_lat),
  .stat_view (stat_view),
  .irq       (irq)
);

// File: tb/test_spi_csr_unit.sv
module test_spi_csr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_push, rx_pop, irq, ctrl_en;
  logic [7:0]  tx_byte, rx_byte = 8'h00, idle_count;
  logic [4:0]  tx_level = '0;
  logic        tx_full = 1'b0, rx_nonempty = 1'b0, mode_fault = 1'b0;
  logic [17:0] cfg_word;
  logic [31:0] delay_word;
  logic [3:0]  wm_level;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  spi_csr_unit i_spi_csr_unit (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_byte(tx_byte),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .tx_level(tx_level), .tx_full(tx_full),
    .rx_nonempty(rx_nonempty), .mode_fault(mode_fault), .cfg_word(cfg_word),
    .ctrl_en(ctrl_en), .delay_word(delay_word), .idle_count(idle_count),
    .wm_level(wm_level), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cfg, m_dly, m_idle, m_wm, m_mask, m_rdata;
  logic        m_en, m_modf, m_txlow, m_prev, m_full, m_rxne, m_irq, m_push, m_pop;
  logic [7:0]  m_byte;

  function automatic logic [31:0] view();
    return {27'd0, m_rxne, m_full, m_txlow, m_modf, 1'b0};
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cfg = 0; m_dly = 0; m_idle = 0; m_wm = 1; m_mask = 0; m_rdata = 0;
      m_en = 0; m_modf = 0; m_txlow = 0; m_prev = 0; m_full = 0; m_rxne = 0;
      m_irq = 0; m_push = 0; m_pop = 0; m_byte = 0;
    end else begin
      logic cond;
      logic [3:0] ix;
      logic w, r;
      cond = int'(tx_level) < int'(m_wm);
      ix = bus_addr[5:2];
      w = bus_sel && bus_wr;
      r = bus_sel && !bus_wr;
      m_irq = |(view() & m_mask);
      m_rdata = 0;
      if (r) begin
        case (ix)
          4'd0: m_rdata = m_cfg;
          4'd1: m_rdata = view();
          4'd4: m_rdata = m_mask;
          4'd5: m_rdata = {31'd0, m_en};
          4'd6: m_rdata = m_dly;
          4'd8: m_rdata = {24'd0, rx_byte};
          4'd9: m_rdata = m_idle;
          4'd10: m_rdata = m_wm;
          default: m_rdata = 0;
        endcase
      end
      m_pop = r && ix == 4'd8;
      m_push = w && ix == 4'd7;
      if (m_push) m_byte = bus_wdata[7:0];
      m_modf  = (m_modf  && !(w && ix == 4'd1 && bus_wdata[1])) || mode_fault;
      m_txlow = (m_txlow && !(w && ix == 4'd1 && bus_wdata[2])) || (cond && !m_prev);
      m_prev = cond;
      m_full = tx_full;
      m_rxne = rx_nonempty;
      if (w) begin
        case (ix)
          4'd0: m_cfg = bus_wdata & 32'h3FFFF;
          4'd2: m_mask = m_mask | (bus_wdata & 32'h7F);
          4'd3: m_mask = m_mask & ~(bus_wdata & 32'h7F);
          4'd5: m_en = bus_wdata[0];
          4'd6: m_dly = bus_wdata;
          4'd9: m_idle = bus_wdata & 32'hFF;
          4'd10: m_wm = bus_wdata & 32'hF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R10 tx_push", {31'd0, tx_push}, {31'd0, m_push});
    if (m_push) chk("R10 tx_byte", {24'd0, tx_byte}, {24'd0, m_byte});
    chk("R11 rx_pop", {31'd0, rx_pop}, {31'd0, m_pop});
    chk("R12 rdata", bus_rdata, m_rdata);
    chk("R2 cfg_word", {14'd0, cfg_word}, m_cfg);
    chk("R2 ctrl_en", {31'd0, ctrl_en}, {31'd0, m_en});
    chk("R2 delay_word", delay_word, m_dly);
    chk("R2 idle_count", {24'd0, idle_count}, m_idle);
    chk("R3 wm_level", {28'd0, wm_level}, m_wm);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    rd(6'h10, d); chk("R1 mask reset", d, 32'h0);
    rd(6'h28, d); chk("R1 watermark reset", d, 32'h1);
    rd(6'h14, d); chk("R1 enable reset", d, 32'h0);
    // R2 RW registers
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); chk("R2 config", d, 32'h3FFFF);
    wr(6'h18, 32'hA5A5_1234); rd(6'h18, d); chk("R2 delay", d, 32'hA5A5_1234);
    wr(6'h24, 32'h1FF); rd(6'h24, d); chk("R2 idle", d, 32'hFF);
    wr(6'h14, 32'h3); rd(6'h14, d); chk("R2 enable", d, 32'h1);
    // R3 watermark truncation
    wr(6'h28, 32'hFFFF); rd(6'h28, d); chk("R3 depth-1", d, 32'd15);
    wr(6'h28, 32'd4);
    // R4 mask set/clear
    wr(6'h08, 32'h16); wr(6'h0C, 32'h04);
    rd(6'h10, d); chk("R4 mask", d, 32'h12);
    rd(6'h08, d); chk("R12 set reg reads 0", d, 32'h0);
    rd(6'h2C, d); chk("R12 unmapped reads 0", d, 32'h0);
    // R7 latched after reset, clear, no re-set while low
    rd(6'h04, d); chk("R7 set after reset", d, 32'h04);
    wr(6'h04, 32'h7F); idle(2);
    rd(6'h04, d); chk("R7 no re-set while low", d, 32'h0);
    tx_level = 5'd6; idle(2);
    tx_level = 5'd2; idle(2);
    rd(6'h04, d); chk("R7 rising edge sets", d, 32'h04);
    wr(6'h04, 32'h04);
    // R6 mode fault, R5 zero write no effect
    mode_fault = 1; idle(1); mode_fault = 0; idle(2);
    chk("R9 irq on masked modf", {31'd0, irq}, 32'h1);
    wr(6'h04, 32'h0); rd(6'h04, d); chk("R5 zero write keeps", d, 32'h02);
    wr(6'h04, 32'h02); rd(6'h04, d); chk("R5 w1c clears", d, 32'h0);
    idle(1); chk("R9 irq drops", {31'd0, irq}, 32'h0);
    // R6 set wins over clear in same cycle
    mode_fault = 1; wr(6'h04, 32'h02); mode_fault = 0;
    rd(6'h04, d); chk("R6 set wins", d, 32'h02);
    wr(6'h04, 32'h7F);
    // R8 level bits
    tx_full = 1; rx_nonempty = 1; idle(1);
    wr(6'h04, 32'h18);
    rd(6'h04, d); chk("R8 level bits", d, 32'h18);
    wr(6'h0C, 32'h7F); wr(6'h08, 32'h10); idle(2);
    chk("R9 irq from rxne", {31'd0, irq}, 32'h1);
    rx_nonempty = 0; idle(2);
    chk("R9 irq follows rxne", {31'd0, irq}, 32'h0);
    tx_full = 0;
    // R10 pushes back to back, R11 pops
    wr(6'h1C, 32'h1234_56AB); wr(6'h1C, 32'h0000_0077);
    rx_byte = 8'h3C; rd(6'h20, d); chk("R11 rx data", d, 32'h3C);
    rx_byte = 8'hC3; rd(6'h20, d); chk("R11 rx data 2", d, 32'hC3);
    rd(6'h1C, d); chk("R12 tx reg reads 0", d, 32'h0);
    // R1 reset mid-run
    rst = 1; idle(2); rst = 0; idle(1);
    rd(6'h28, d); chk("R1 wm after reset", d, 32'h1);
    rd(6'h10, d); chk("R1 mask after reset", d, 32'h0);
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule